// File: doc/BRIEF.md
# Level-Sensitive 32-Source Interrupt Combiner

This block gathers thirty-two level-sensitive interrupt inputs and presents them to a processor as one request line. Every source owns one bit position in every register. Each clock cycle the raw input levels are sampled into a status register. A per-source disable bit masks the sampled levels to form the pending view. Set disable bits mean a source is blocked. Software never rewrites the disable register directly. It writes a word to a set alias to block sources, or a word to a clear alias to unblock them. Every 1 in the word acts on that bit, and every 0 leaves its bit alone, so no read-modify-write is needed.

The combined request goes to the processor one register stage after the OR of all pending bits. The request stage is a two-state machine. In `REQ_QUIET` the output is low. The transition `QUIET_TO_RAISED` is taken when any pending bit is set. In `REQ_RAISED` the output is high. The transition `RAISED_TO_QUIET` is taken when no pending bit is set. A lowest-index encoder gives dispatch code the number of the first pending source, together with a valid flag.

The bus is a plain word port: a write strobe, a byte offset, write data, and read data that follows the offset combinationally. The five registers sit at fixed offsets in a 0x14-byte window.

Top module: `lvl_irq_hub`

## Requirements
- R1: After reset the disable register reads 0xFFFFFFFF. Status reads 0, `irq_req` is 0, `irq_id_valid` is 0 and `irq_id` is 0.
- R2: Offset 0x00 reads the source levels that were sampled at the previous rising clock edge.
- R3: A write to offset 0x08 sets the disable bit for every 1 in the write data. Bits written as 0 keep their value.
- R4: A write to offset 0x0C clears the disable bit for every 1 in the write data. Bits written as 0 keep their value.
- R5: Offset 0x04 reads the current 32-bit disable register.
- R6: Writes to offsets 0x00, 0x04 and 0x10 change neither the disable register nor any pending bit.
- R7: Offset 0x10 reads the status value ANDed with the inverse of the disable register.
- R8: `irq_req` equals the OR of the pending bits delayed by one clock cycle.
- R9: While any bit is pending, `irq_id` is the index of the lowest pending bit and `irq_id_valid` is 1. Otherwise both are 0.
- R10: Reads at offsets 0x14 and above return 0, and writes there have no effect.
- R11: A pending bit stays set only while its source input is held high. It drops one cycle after the input falls, with no software action.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising-edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_lvl | input | 32 | Raw level of each interrupt source |
| bus_we | input | 1 | Write strobe for one cycle |
| bus_addr | input | 5 | Byte offset of the register accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| irq_req | output | 1 | Combined request to the processor |
| irq_id | output | 5 | Index of the lowest pending source |
| irq_id_valid | output | 1 | High when some source is pending |

## Verification
The bound checker covers the following on every cycle:
- the set and clear alias updates of the disable register;
- that the disable register holds when no alias write occurs;
- the one-cycle lag of the request line behind the pending OR;
- the lowest-index property of the encoder;
- that status follows the sampled source levels;
- the all-ones disable state on leaving reset.

Some behaviours are visible only through the bench's scenarios, because they involve bus decode as seen from the ports:
- that ignored offsets leave the read-back state untouched;
- that out-of-window offsets read zero;
- the end-to-end timing from a source edge to the request output;
- that a level source drops out of pending without any acknowledge.

// File: rtl/irqh_pkg.sv
package irqh_pkg;

    localparam int OFS_W = 5;

    localparam logic [OFS_W-1:0] OFS_STATUS  = 5'h00;
    localparam logic [OFS_W-1:0] OFS_DISABLE = 5'h04;
    localparam logic [OFS_W-1:0] OFS_DIS_SET = 5'h08;
    localparam logic [OFS_W-1:0] OFS_DIS_CLR = 5'h0C;
    localparam logic [OFS_W-1:0] OFS_PENDING = 5'h10;

    typedef enum logic {
        REQ_QUIET  = 1'b0,
        REQ_RAISED = 1'b1
    } req_state_e;

endpackage

// File: rtl/irqh_src_latch.sv
module irqh_src_latch #(
    parameter int N_SRC = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] src_lvl,
    output logic [N_SRC-1:0] status_q
);

    // Sample every raw level once per cycle; no edge capture.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status_q <= '0;
        end else begin
            status_q <= src_lvl;
        end
    end

endmodule

// File: rtl/irqh_mask_bank.sv
module irqh_mask_bank
    import irqh_pkg::*;
#(
    parameter int N_SRC = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_we,
    input  logic [OFS_W-1:0] bus_addr,
    input  logic [N_SRC-1:0] bus_wdata,
    output logic [N_SRC-1:0] dis_q
);

    logic set_hit;
    logic clr_hit;

    assign set_hit = bus_we && (bus_addr == OFS_DIS_SET);
    assign clr_hit = bus_we && (bus_addr == OFS_DIS_CLR);

    // One cell per source; each cell reacts only to its own data bit.
    for (genvar g = 0; g < N_SRC; g++) begin : g_cell
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                dis_q[g] <= 1'b1;
            end else if (set_hit && bus_wdata[g]) begin
                dis_q[g] <= 1'b1;
            end else if (clr_hit && bus_wdata[g]) begin
                dis_q[g] <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/irqh_lowest_enc.sv
module irqh_lowest_enc #(
    parameter int N_SRC = 32,
    localparam int ID_W = $clog2(N_SRC)
) (
    input  logic [N_SRC-1:0] pend,
    output logic [ID_W-1:0]  id,
    output logic             id_valid
);

    // Walk from the top down so the lowest set index wins.
    always_comb begin
        id       = '0;
        id_valid = 1'b0;
        for (int i = N_SRC - 1; i >= 0; i--) begin
            if (pend[i]) begin
                id       = ID_W'(i);
                id_valid = 1'b1;
            end
        end
    end

endmodule

// File: rtl/irqh_req_fsm.sv
module irqh_req_fsm
    import irqh_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic any_pend,
    output logic irq_req
);

    req_state_e state_q;
    req_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            REQ_QUIET:  if (any_pend)  state_d = REQ_RAISED;  // QUIET_TO_RAISED
            REQ_RAISED: if (!any_pend) state_d = REQ_QUIET;   // RAISED_TO_QUIET
            default:    state_d = REQ_QUIET;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= REQ_QUIET;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        irq_req = (state_q == REQ_RAISED);
    end

endmodule

// File: rtl/lvl_irq_hub.sv
module lvl_irq_hub
    import irqh_pkg::*;
#(
    parameter int N_SRC = 32,
    localparam int ID_W = $clog2(N_SRC)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] src_lvl,
    input  logic             bus_we,
    input  logic [OFS_W-1:0] bus_addr,
    input  logic [N_SRC-1:0] bus_wdata,
    output logic [N_SRC-1:0] bus_rdata,
    output logic             irq_req,
    output logic [ID_W-1:0]  irq_id,
    output logic             irq_id_valid
);

    logic [N_SRC-1:0] status_q;
    logic [N_SRC-1:0] dis_q;
    logic [N_SRC-1:0] pend;

    irqh_src_latch #(.N_SRC(N_SRC)) u_latch (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_lvl  (src_lvl),
        .status_q (status_q)
    );

    irqh_mask_bank #(.N_SRC(N_SRC)) u_mask (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .dis_q     (dis_q)
    );

    assign pend = status_q & ~dis_q;

    irqh_lowest_enc #(.N_SRC(N_SRC)) u_enc (
        .pend     (pend),
        .id       (irq_id),
        .id_valid (irq_id_valid)
    );

    irqh_req_fsm u_req (
        .clk      (clk),
        .rst_n    (rst_n),
        .any_pend (|pend),
        .irq_req  (irq_req)
    );

    always_comb begin
        unique case (bus_addr)
            OFS_STATUS:  bus_rdata = status_q;
            OFS_DISABLE: bus_rdata = dis_q;
            OFS_PENDING: bus_rdata = pend;
            default:     bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/lvl_irq_hub_chk.sv
module lvl_irq_hub_chk
    import irqh_pkg::*;
#(
    parameter int N_SRC = 32,
    localparam int ID_W = $clog2(N_SRC)
) (
    input logic             clk,
    input logic             rst_n,
    input logic [N_SRC-1:0] src_lvl,
    input logic             bus_we,
    input logic [OFS_W-1:0] bus_addr,
    input logic [N_SRC-1:0] bus_wdata,
    input logic [N_SRC-1:0] status_q,
    input logic [N_SRC-1:0] dis_q,
    input logic [N_SRC-1:0] pend,
    input logic             irq_req,
    input logic [ID_W-1:0]  irq_id,
    input logic             irq_id_valid
);

    logic set_wr;
    logic clr_wr;
    assign set_wr = bus_we && (bus_addr == OFS_DIS_SET);
    assign clr_wr = bus_we && (bus_addr == OFS_DIS_CLR);

    p_reset_mask_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (dis_q == '1));

    p_status_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (status_q == $past(src_lvl)));

    p_set_alias_r3: assert property (@(posedge clk) disable iff (!rst_n)
        set_wr |=> (dis_q == ($past(dis_q) | $past(bus_wdata))));

    p_clr_alias_r4: assert property (@(posedge clk) disable iff (!rst_n)
        clr_wr |=> (dis_q == ($past(dis_q) & ~$past(bus_wdata))));

    p_mask_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(set_wr || clr_wr) |=> $stable(dis_q));

    p_req_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (|pend) |=> irq_req);

    p_req_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(|pend) |=> !irq_req);

    p_id_lowest_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_id_valid |-> (pend[irq_id] &&
            ((pend & ((N_SRC'(1) << irq_id) - N_SRC'(1))) == '0)));

    p_id_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pend == '0) |-> (!irq_id_valid && irq_id == '0));

endmodule

bind lvl_irq_hub lvl_irq_hub_chk #(.N_SRC(N_SRC)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .src_lvl      (src_lvl),
    .bus_we       (bus_we),
    .bus_addr     (bus_addr),
    .bus_wdata    (bus_wdata),
    .status_q     (status_q),
    .dis_q        (dis_q),
    .pend         (pend),
    .irq_req      (irq_req),
    .irq_id       (irq_id),
    .irq_id_valid (irq_id_valid)
);

// File: tb/lvl_irq_hub_tb.sv
module lvl_irq_hub_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src_lvl = '0;
    logic        bus_we = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_req;
    logic [4:0]  irq_id;
    logic        irq_id_valid;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [31:0] model_dis;

    always #5 clk = ~clk;

    lvl_irq_hub u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .src_lvl      (src_lvl),
        .bus_we       (bus_we),
        .bus_addr     (bus_addr),
        .bus_wdata    (bus_wdata),
        .bus_rdata    (bus_rdata),
        .irq_req      (irq_req),
        .irq_id       (irq_id),
        .irq_id_valid (irq_id_valid)
    );

    // Stimulus rows: {source levels, set-alias word, clear-alias word}
    localparam logic [95:0] VECS [0:5] = '{
        {32'h0000_0001, 32'h0000_0000, 32'h0000_0001},
        {32'h8000_0010, 32'h0000_0000, 32'h8000_0000},
        {32'h8000_0011, 32'h0000_0000, 32'h0000_0010},
        {32'hFFFF_FFFF, 32'h0000_0011, 32'h0000_0000},
        {32'h0F0F_0000, 32'hFFFF_FFFF, 32'h0000_0300},
        {32'h0000_0200, 32'h0000_0000, 32'h0000_0C00}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    function automatic logic [5:0] lowest(input logic [31:0] p);
        logic [5:0] r = 6'd0;
        for (int i = 31; i >= 0; i--) if (p[i]) r = {1'b1, 5'(i)};
        return r;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; src_lvl = '0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        model_dis = 32'hFFFF_FFFF;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=%08h expected=%08h", 0, 1);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic [31:0] exp_p;
        logic [5:0]  e;
        model_dis = 32'hFFFF_FFFF;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(5'h04, d); chk("R1 disable after reset", d, 32'hFFFF_FFFF);
        rd(5'h00, d); chk("R1 status after reset", d, 32'h0);
        chk("R1 irq_req after reset", {31'd0, irq_req}, 32'h0);
        chk("R1 id after reset", {26'd0, irq_id_valid, irq_id}, 32'h0);

        // Vector walk: R2 R3 R4 R5 R7 R8 R9
        for (int v = 0; v < 6; v++) begin
            @(negedge clk);
            src_lvl = VECS[v][95:64];
            wr(5'h08, VECS[v][63:32]);
            model_dis = model_dis | VECS[v][63:32];
            wr(5'h0C, VECS[v][31:0]);
            model_dis = model_dis & ~VECS[v][31:0];
            @(negedge clk);
            exp_p = VECS[v][95:64] & ~model_dis;
            e = lowest(exp_p);
            rd(5'h04, d); chk("R3/R4 R5 disable readback", d, model_dis);
            rd(5'h00, d); chk("R2 status", d, VECS[v][95:64]);
            rd(5'h10, d); chk("R7 pending", d, exp_p);
            chk("R9 id/valid", {26'd0, irq_id_valid, irq_id}, {26'd0, e});
            chk("R8 irq_req", {31'd0, irq_req}, {31'd0, |exp_p});
        end

        // R6 ignored writes to status, disable and pending offsets
        wr(5'h04, 32'h0000_0000);
        wr(5'h00, 32'hFFFF_FFFF);
        wr(5'h10, 32'hFFFF_FFFF);
        rd(5'h04, d); chk("R6 disable unchanged", d, model_dis);
        rd(5'h10, d); chk("R6 pending unchanged", d, 32'h0000_0200);

        // R10 out-of-window offsets
        wr(5'h14, 32'hFFFF_FFFF);
        wr(5'h18, 32'hFFFF_FFFF);
        rd(5'h14, d); chk("R10 read 0x14", d, 32'h0);
        rd(5'h1C, d); chk("R10 read 0x1C", d, 32'h0);
        rd(5'h04, d); chk("R10 disable unchanged", d, model_dis);

        // R8 / R11 edge timing on a single source
        src_lvl = '0;
        wr(5'h0C, 32'h0000_0020);
        model_dis = model_dis & ~32'h0000_0020;
        @(negedge clk);
        src_lvl = 32'h0000_0020;
        @(negedge clk);
        rd(5'h10, d); chk("R11 pending on rise", d, 32'h0000_0020);
        chk("R8 irq lags pending", {31'd0, irq_req}, 32'h0);
        chk("R9 id for source 5", {26'd0, irq_id_valid, irq_id}, {26'd0, 1'b1, 5'd5});
        @(negedge clk);
        chk("R8 irq raised", {31'd0, irq_req}, 32'h1);
        src_lvl = '0;
        @(negedge clk);
        rd(5'h10, d); chk("R11 pending drops with level", d, 32'h0);
        chk("R8 irq still high", {31'd0, irq_req}, 32'h1);
        @(negedge clk);
        chk("R8 irq dropped", {31'd0, irq_req}, 32'h0);

        // R1 reset in mid-run
        do_reset();
        @(negedge clk);
        rd(5'h04, d); chk("R1 disable after second reset", d, 32'hFFFF_FFFF);
        chk("R1 id after second reset", {26'd0, irq_id_valid, irq_id}, 32'h0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule